// File: doc/BRIEF.md
# Prescaled Up-Counting Timer

This block is a general-purpose up-counter with a clock divider in front of it. Software writes it through a plain write strobe. It can set the counting period and the divide ratio, start and stop the timer, choose whether a period write acts at once or is staged, and suppress overflow events. When the counter reaches the period it wraps to zero. Each wrap normally raises a one-cycle overflow pulse and a sticky overflow flag, which software clears.

The divide ratio always passes through a shadow copy. The period passes through a shadow copy when staging is on. Both shadows are refreshed only at an overflow event. A debug-halt input freezes all counting while it is held. Outputs show the count, the flag, the overflow pulse and the internal run state, so the timer can be watched from outside.

Register map, addressed by `wr_addr_i`:

- Address 0 is control. Bit 0 is enable, bit 1 is period staging and bit 2 is event disable.
- Address 1 is the period.
- Address 2 is the divide value.
- Address 3 is status. Writing 1 to bit 0 clears the flag.

Top module: `prescaled_timer`

## Requirements
- R1: `active_o` is 1 in the cycle after the control enable bit (address 0, bit 0) has been 1 for one clock edge. The counter and divider advance only on clock edges at which `active_o` is 1 and `dbg_halt_i` is 0. The first count step therefore lands two edges after the enabling write.
- R2: The counter steps from 0 up to the active period. On the step taken at a count greater than or equal to the active period, it goes to 0 instead. When events are enabled, that wrap is an overflow event, and `ovf_evt_o` is 1 for the cycle after it.
- R3: Every overflow event sets `ovf_flag_o`. The flag stays at 1 until software writes 1 to bit 0 at address 3, and it never rises without an event.
- R4: With staging off (control bit 1 = 0), a new period written to address 1 governs the wrap comparison from the very next step.
- R5: With staging on (control bit 1 = 1), a new period is held back. It governs the wrap comparison only after the next overflow event.
- R6: A divide value written to address 2 takes effect only after the next overflow event.
- R7: With divide value D active, the counter makes one step every D+1 clock edges on which counting is allowed.
- R8: While `dbg_halt_i` is 1, neither the counter nor the divider changes.
- R9: With events disabled (control bit 2 = 1), the counter still wraps. No pulse appears, the flag is untouched, and neither shadow is reloaded.
- R10: A flag clear written in the same cycle as an overflow event leaves the flag at 1.
- R11: Clearing the enable bit stops counting, after the same one-clock lag as in R1. The counter keeps its value, and counting later resumes from that value.
- R12: After reset the count is 0, the flag, the pulse and `active_o` are 0, the divide value is 0, and the period is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| dbg_halt_i | input | 1 | Debug halt, freezes counting while 1 |
| cnt_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_evt_o | output | 1 | One-cycle overflow event pulse |
| active_o | output | 1 | Internal run state, lags the enable bit by one clock |

## Verification
The properties assume that the only way to clear the flag is a write of 1 to bit 0 at address 3. They also assume that no step can move the count by more than one. This holds only because a write never touches the count register directly. The stimulus keeps each register write a single cycle long and never lowers the period below the current count while staging is off. Halt windows are placed where the count is nonzero, so that a frozen value can be told apart from a count that is still moving.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_DIV  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd3;

    // bit 0 en, bit 1 stage, bit 2 evt_dis
    typedef struct packed {
        logic evt_dis;
        logic stage;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int            CNT_W   = 16,
    parameter int            DIV_W   = 16,
    parameter int            DATA_W  = 16,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              evt_now_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              flag_o,
    output logic              run_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per;
        logic [DIV_W-1:0] dv;
        logic             flag;
        logic             run;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    clr;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                ADR_CTRL: st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ADR_PER:  st_d.per  = wr_data_i[CNT_W-1:0];
                ADR_DIV:  st_d.dv   = wr_data_i[DIV_W-1:0];
                default:  clr       = wr_data_i[0];
            endcase
        end
        // a new event outranks a simultaneous clear
        st_d.flag = (st_q.flag & ~clr) | evt_now_i;
        // one-clock synchroniser stage on the enable
        st_d.run  = st_q.ctrl.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.per  <= PER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign per_o  = st_q.per;
    assign div_o  = st_q.dv;
    assign flag_o = st_q.flag;
    assign run_o  = st_q.run;

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
    parameter int               CNT_W   = 16,
    parameter int               DIV_W   = 16,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             halt_i,
    input  logic             stage_i,
    input  logic             evt_dis_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_now_o,
    output logic             evt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div_cnt;
        logic [DIV_W-1:0] div_sh;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_sh;
        logic             evt;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] per_act;
    logic             tick;

    always_comb begin
        st_d      = st_q;
        evt_now_o = 1'b0;
        per_act   = stage_i ? st_q.per_sh : per_i;
        tick      = run_i & ~halt_i;
        // unstaged: shadow tracks the register so a later switch is seamless
        if (!stage_i) st_d.per_sh = per_i;
        if (tick) begin
            if (st_q.div_cnt >= st_q.div_sh) begin
                st_d.div_cnt = '0;
                if (st_q.cnt >= per_act) begin
                    st_d.cnt = '0;
                    if (!evt_dis_i) begin
                        evt_now_o   = 1'b1;
                        st_d.div_sh = div_i;
                        st_d.per_sh = per_i;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.div_cnt = st_q.div_cnt + 1'b1;
            end
        end
        st_d.evt = evt_now_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.per_sh <= PER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign evt_o = st_q.evt;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               DIV_W   = 16,
    parameter int               DATA_W  = 16,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              dbg_halt_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_flag_o,
    output logic              ovf_evt_o,
    output logic              active_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per;
    logic [DIV_W-1:0] dv;
    logic             evt_now;

    ptmr_regs #(
        .CNT_W   (CNT_W),
        .DIV_W   (DIV_W),
        .DATA_W  (DATA_W),
        .PER_RST (PER_RST)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .evt_now_i (evt_now),
        .ctrl_o    (ctrl),
        .per_o     (per),
        .div_o     (dv),
        .flag_o    (ovf_flag_o),
        .run_o     (active_o)
    );

    ptmr_core #(
        .CNT_W   (CNT_W),
        .DIV_W   (DIV_W),
        .PER_RST (PER_RST)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (active_o),
        .halt_i    (dbg_halt_i),
        .stage_i   (ctrl.stage),
        .evt_dis_i (ctrl.evt_dis),
        .per_i     (per),
        .div_i     (dv),
        .cnt_o     (cnt_o),
        .evt_now_o (evt_now),
        .evt_o     (ovf_evt_o)
    );

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              dbg_halt_i,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              ovf_flag_o,
    input logic              ovf_evt_o,
    input logic              active_o
);

    logic clr_wr;
    assign clr_wr = wr_en_i && (wr_addr_i == ADR_STAT) && wr_data_i[0];

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> $stable(cnt_o));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_o |-> (cnt_o == '0));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !clr_wr) |=> ovf_flag_o);

    assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_flag_o |=> (ovf_flag_o == ovf_evt_o));

    assert_flag_on_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_o |-> ovf_flag_o);

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halt_i |=> $stable(cnt_o));

    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !dbg_halt_i) |=>
            ($stable(cnt_o) || (cnt_o == '0) ||
             (cnt_o == CNT_W'($past(cnt_o) + 1'b1))));

endmodule

bind prescaled_timer ptmr_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .dbg_halt_i (dbg_halt_i),
    .cnt_o      (cnt_o),
    .ovf_flag_o (ovf_flag_o),
    .ovf_evt_o  (ovf_evt_o),
    .active_o   (active_o)
);

// File: tb/prescaled_timer_tb_top.sv
`timescale 1ns/1ps
module prescaled_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        halt = 1'b0;
    logic [15:0] cnt;
    logic        flag, evt, active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prescaled_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .dbg_halt_i (halt),
        .cnt_o      (cnt),
        .ovf_flag_o (flag),
        .ovf_evt_o  (evt),
        .active_o   (active)
    );

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic wait_to(input int edge_n);
        while (cyc < edge_n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_evt(input int edge_n);
        exp_q.push_back(edge_n);
    endtask

    // monitor: pops expected overflow edges as events appear
    always @(negedge clk) begin
        if (rst_n && evt) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2/R9 unexpected event: got edge %0d expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R2 event edge: got %0d expected %0d", cyc, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 count", cnt, 0);
        check("R12 flag", flag, 0);
        check("R12 active", active, 0);
        check("R12 pulse", evt, 0);

        wr(2'd1, 16'd5);
        // R1 enable lag
        wr(2'd0, 16'h0001);
        n = cyc;
        check("R1 active one edge later", active, 0);
        expect_evt(n + 7); expect_evt(n + 13); expect_evt(n + 19);
        wait_to(n + 1);
        check("R1 active", active, 1);
        check("R1 no step yet", cnt, 0);
        wait_to(n + 2);
        check("R1 first step", cnt, 1);
        wait_to(n + 20);
        check("R3 flag set", flag, 1);
        // R11 disable keeps value
        wr(2'd0, 16'h0000);
        wait_to(n + 24);
        check("R11 held count", cnt, 3);
        wr(2'd3, 16'h0001);
        check("R3 flag cleared", flag, 0);

        wait_to(n + 29);
        wr(2'd0, 16'h0001);
        e = cyc;
        expect_evt(e + 4); expect_evt(e + 10);
        wait_to(e + 3);
        check("R11 resume from held", cnt, 5);
        wait_to(e + 4);
        wr(2'd3, 16'h0001);
        check("R3 clear", flag, 0);
        wait_to(e + 9);
        wr(2'd3, 16'h0001);
        check("R10 clear with event", flag, 1);

        // R4 immediate period
        wr(2'd1, 16'd2);
        expect_evt(e + 13); expect_evt(e + 16); expect_evt(e + 19);
        wait_to(e + 19);
        // R5 staged period
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'd7);
        expect_evt(e + 22); expect_evt(e + 30); expect_evt(e + 38);
        wait_to(e + 38);
        // R6 divider write waits for event
        wr(2'd2, 16'd3);
        expect_evt(e + 46); expect_evt(e + 78); expect_evt(e + 110);
        wait_to(e + 49);
        check("R7 divided no step", cnt, 0);
        wait_to(e + 50);
        check("R7 divided step", cnt, 1);

        // R8 halt
        wait_to(e + 129);
        halt = 1'b1;
        expect_evt(e + 152);
        wait_to(e + 139);
        check("R8 frozen", cnt, 4);
        halt = 1'b0;
        wait_to(e + 140);
        check("R8 resumed", cnt, 5);

        // R9 events disabled
        wait_to(e + 152);
        wr(2'd0, 16'h0007);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd0);
        wait_to(e + 159);
        wr(2'd3, 16'h0001);
        wait_to(e + 170);
        check("R9 period shadow kept", cnt, 4);
        wait_to(e + 186);
        check("R9 wrapped divider kept", cnt, 0);
        check("R9 flag untouched", flag, 0);
        wait_to(e + 189);
        wr(2'd0, 16'h0003);
        expect_evt(e + 216); expect_evt(e + 220); expect_evt(e + 224);
        wait_to(e + 226);
        check("R2 all events seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule